// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital side of a successive-approximation analog-to-digital converter. An analog front end outside the block holds the channel multiplexer, a trial DAC and a comparator. The controller picks the channel, drives the trial DAC code and a sample/hold strobe, and reads back one comparator bit on each trial. It searches the result from the most significant bit down and writes each finished result into a per-channel result register. A one-cycle done pulse marks each write, and software reads the registers through a small combinational read port.

A conversion starts in one of two ways. A software write of the start flag starts it directly. In external mode, the flag only arms the block, and a falling edge on the trigger pin starts the conversion, or restarts it if one is already running. Several settings change how long a conversion takes and in what order channels are visited: a prescaler setting, a choice of 8-bit or 10-bit resolution, a sample/hold enable, and five sequencing modes. The modes are one channel once, one channel repeatedly, the eight main channels once, the eight main channels repeatedly, and the main channels interleaved with one priority channel repeatedly. Nothing starts unless the reference-connect enable is high.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The conversion clock is the input clock divided by 1, 2 or 4 for `clk_sel` equal to 0, 1 or 2 (3 also divides by 4), and the divider restarts at each channel start.
- R2: One channel takes 49 conversion-clock ticks at 8 bits and 59 at 10 bits with `sh_en`=0, and 28 and 33 with `sh_en`=1. `done` is high in clock cycle divide×ticks after the launching edge.
- R3: `cmp_in`=1 means the selected input is at or above `dac_code`. The search keeps each trial bit from bit 9 downward for which the comparator returns 1. At 8 bits (`res10`=0) only bits 9..2 are tried and bits 1..0 stay 0.
- R4: A 10-bit result is read as `rd_lo` = result bits 7..0 and `rd_hi` = bits 9..8. An 8-bit result is read as `rd_lo` = bits 9..2 and `rd_hi` = 0. After reset every channel reads 0.
- R5: With `ext_mode`=0, a one-cycle `start_set` pulse while the flag is 0 and `vref_en`=1 sets `start_flag` and starts the conversion at that clock edge.
- R6: While `vref_en`=0, a `start_set` pulse is ignored: `start_flag` stays 0 and `busy` stays 0.
- R7: With `ext_mode`=1, `start_set` only sets the flag. The conversion starts on a falling edge of `ext_trig_n`, seen through a two-stage synchronizer, while the flag is 1. The start edge comes three clock edges after the pin falls.
- R8: A new falling edge on `ext_trig_n` during a conversion abandons it and starts again from the first channel, so `done` comes a full conversion after the new edge and never before it.
- R9: In `mode`=0 (one-shot), channel `chan_sel` is converted once and `start_flag` and `busy` are both 0 in the cycle that `done` is high.
- R10: In `mode`=1 (repeat), channel `chan_sel` is converted back to back, with consecutive `done` pulses divide×ticks apart, for as long as the flag is 1. A `start_clr` pulse clears the flag and stops the conversion, and `busy` is 0 from the next cycle on.
- R11: In `mode`=2 (single sweep), channels 0 to 7 are converted once in rising order, and the flag clears with the result of channel 7.
- R12: In `mode`=3 (repeat sweep), channels 0 to 7 are converted in rising order, wrapping from 7 back to 0 while the flag is 1.
- R13: In `mode`=4 (interleaved sweep), the channel order is `chan_sel`, 0, `chan_sel`, 1, and so on up to `chan_sel`, 7, repeated while the flag is 1.
- R14: `done` is a one-cycle pulse and `done_chan` names the channel. In that same cycle the read port already returns the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Conversion clock divide select |
| res10 | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| sh_en | input | 1 | Sample/hold enable (shorter conversion) |
| mode | input | 3 | Sequencing mode 0..4 |
| chan_sel | input | 4 | Channel for single-channel modes, priority channel for mode 4 |
| ext_mode | input | 1 | 1 = start on external trigger edge |
| ext_trig_n | input | 1 | External trigger, active on falling edge, asynchronous |
| vref_en | input | 1 | Reference-connect enable, gates every start |
| start_set | input | 1 | Software write of 1 to the start flag (pulse) |
| start_clr | input | 1 | Software write of 0 to the start flag (pulse) |
| cmp_in | input | 1 | Comparator: input at or above DAC code |
| dac_code | output | 10 | Trial code to the DAC |
| sample_hold | output | 1 | High while the input is being sampled |
| chan_o | output | 4 | Channel multiplexer select |
| busy | output | 1 | Conversion in progress |
| start_flag | output | 1 | Start flag state |
| done | output | 1 | One-cycle pulse after a result is written |
| done_chan | output | 4 | Channel of the result just written |
| rd_chan | input | 4 | Read port channel select |
| rd_lo | output | 8 | Low byte of the selected result |
| rd_hi | output | 2 | High bits of the selected result |

## Verification
Every result has a known arrival cycle. A software start puts `done` in the negedge sample that follows divide×ticks+1 rising edges after the drive. An external edge puts it after divide×ticks+3, because the synchronizer and the edge detector add two edges. A continuing repeat or sweep spaces the pulses exactly divide×ticks apart. The bench counts rising edges from the negedge where it drives the stimulus and compares the count with these values, which it works out from the divide and tick tables. Read-port values, flag state and `busy` are sampled on the same negedge as `done`, and `done` is checked low again one cycle later.

// File: rtl/sar_adc_pkg.sv
// Shared types of the successive-approximation controller.
// Assumes: mode codes 5..7 are never written; they act as one-shot.
package sar_adc_pkg;

    typedef enum logic [2:0] {
        M_ONESHOT = 3'd0,
        M_REPEAT  = 3'd1,
        M_SWEEP   = 3'd2,
        M_RSWEEP0 = 3'd3,
        M_RSWEEP1 = 3'd4
    } seq_mode_e;

    typedef enum logic [1:0] {
        E_IDLE   = 2'd0,
        E_SAMPLE = 2'd1,
        E_TRIAL  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/sar_adc_prescaler.sv
// Conversion clock enable generator.
// Produces a one-cycle tick every 1, 2 or 4 input clocks. A clear restarts
// the count so the first tick after a channel start is a full period away.
// Assumes: sel changes only while no conversion is running.
module sar_adc_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // Map the select field to the terminal count.
    always_comb begin
        case (sel)
            2'd0:    lim = DIV_W'(0);
            2'd1:    lim = DIV_W'(1);
            default: lim = DIV_W'(3);
        endcase
    end

    assign tick = (cnt_q == lim);

    // Count input clocks, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + DIV_W'(1);
    end

    // R1: with a divide above 1, ticks never come on two adjacent cycles
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 2'd0) |=> (!tick || sel == 2'd0));

endmodule

// File: rtl/sar_adc_trigger.sv
// Start flag and start-condition logic.
// Holds the software start flag, synchronizes the external trigger and
// detects its falling edge, and decides when a channel run is launched or
// stopped. Assumes: ext_trig_n is asynchronous to clk.
module sar_adc_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic auto_clr,
    input  logic ext_mode,
    input  logic ext_n,
    input  logic vref_en,
    output logic flag,
    output logic launch,
    output logic abort
);
    logic s1_q, s2_q, s3_q;
    logic fall;

    // Two-stage synchronizer plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= ext_n;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign fall = s3_q & ~s2_q;

    // Launch conditions: software write, or armed external edge.
    assign launch = vref_en & (ext_mode ? (fall & flag) : (sw_set & ~flag));
    assign abort  = sw_clr & flag;

    // Start flag: clears win over sets; sets need the reference connected.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag <= 1'b0;
        else if (sw_clr || auto_clr) flag <= 1'b0;
        else if (sw_set && vref_en) flag <= 1'b1;
    end

    // R6: the flag only rises after a write made with the reference connected
    a_r6_flag_needs_vref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(vref_en));

    // R10: a software clear always drops the flag
    a_r10_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> !flag);

endmodule

// File: rtl/sar_adc_engine.sv
// Successive-approximation search for one channel.
// After a start it samples for the ticks left over by the bit trials, then
// tries each bit from the MSB down: the trial bit is driven for a fixed
// settle count and kept if the comparator reads 1 on the last tick.
// fin is high on the final tick, with fin_code the finished code.
// Assumes: res10 and sh_en are stable during a conversion.
module sar_adc_engine
    import sar_adc_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int LO_W        = 8,
    parameter int CNT_W       = 6,
    parameter int T8_NOSH     = 49,
    parameter int T10_NOSH    = 59,
    parameter int T8_SH       = 28,
    parameter int T10_SH      = 33,
    parameter int SETTLE_NOSH = 5,
    parameter int SETTLE_SH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic             res10,
    input  logic             sh_en,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             sampling,
    output logic             busy,
    output logic             fin,
    output logic [RES_W-1:0] fin_code
);
    localparam int BIDX_W = $clog2(RES_W);

    eng_state_e        state_q;
    logic [CNT_W-1:0]  tcnt_q;
    logic [BIDX_W-1:0] bidx_q;
    logic [RES_W-1:0]  code_q;

    logic [CNT_W-1:0]  settle_c, total_c, nbits_c, samp_c;
    logic [BIDX_W-1:0] lowb;
    logic [RES_W-1:0]  trial_bit;
    logic              bit_end;

    // Timing figures for the selected resolution and sample/hold setting.
    always_comb begin
        settle_c = sh_en ? CNT_W'(SETTLE_SH) : CNT_W'(SETTLE_NOSH);
        if (sh_en) total_c = res10 ? CNT_W'(T10_SH)   : CNT_W'(T8_SH);
        else       total_c = res10 ? CNT_W'(T10_NOSH) : CNT_W'(T8_NOSH);
        nbits_c  = res10 ? CNT_W'(RES_W) : CNT_W'(LO_W);
        samp_c   = total_c - (nbits_c * settle_c);
        lowb     = res10 ? BIDX_W'(0) : BIDX_W'(RES_W - LO_W);
    end

    // Trial bit, DAC drive and completion decode.
    always_comb begin
        trial_bit = RES_W'(1) << bidx_q;
        dac_code  = (state_q == E_TRIAL) ? (code_q | trial_bit) : '0;
        bit_end   = tick && (state_q == E_TRIAL) && (tcnt_q == settle_c - CNT_W'(1));
        fin       = bit_end && (bidx_q == lowb);
        fin_code  = cmp_in ? (code_q | trial_bit) : code_q;
    end

    assign sampling = (state_q == E_SAMPLE);
    assign busy     = (state_q != E_IDLE);

    // Sample phase, then one settle window per bit, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= E_IDLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            code_q  <= '0;
        end else if (stop) begin
            state_q <= E_IDLE;
            tcnt_q  <= '0;
        end else if (start) begin
            state_q <= E_SAMPLE;
            tcnt_q  <= '0;
            bidx_q  <= '0;
            code_q  <= '0;
        end else if (tick) begin
            case (state_q)
                E_SAMPLE: begin
                    if (tcnt_q == samp_c - CNT_W'(1)) begin
                        state_q <= E_TRIAL;
                        tcnt_q  <= '0;
                        bidx_q  <= BIDX_W'(RES_W - 1);
                    end else begin
                        tcnt_q  <= tcnt_q + CNT_W'(1);
                    end
                end
                E_TRIAL: begin
                    if (bit_end) begin
                        code_q <= fin_code;
                        tcnt_q <= '0;
                        if (bidx_q == lowb) state_q <= E_IDLE;
                        else                bidx_q  <= bidx_q - BIDX_W'(1);
                    end else begin
                        tcnt_q <= tcnt_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: decided bits do not move between conversion-clock ticks
    a_r3_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_TRIAL && !tick && !start && !stop) |=> $stable(code_q));

    // R2: the final trial ends the channel unless a new one is started
    a_r2_fin_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !start && !stop) |=> !busy);

    // R3: sampling never overlaps a driven trial code
    a_r3_sample_before_trial: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_SAMPLE && tick && tcnt_q != samp_c - CNT_W'(1) && !start && !stop)
            |=> sampling);

endmodule

// File: rtl/sar_adc_result_bank.sv
// Per-channel result storage with a combinational read port.
// Each channel keeps a low byte and a few high bits. An out-of-range read
// channel returns zero, and an out-of-range write channel is dropped.
module sar_adc_result_bank #(
    parameter int NCH  = 10,
    parameter int LO_W = 8,
    parameter int HI_W = 2,
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [CH_W-1:0] wr_ch,
    input  logic [LO_W-1:0] wr_lo,
    input  logic [HI_W-1:0] wr_hi,
    input  logic [CH_W-1:0] rd_ch,
    output logic [LO_W-1:0] rd_lo,
    output logic [HI_W-1:0] rd_hi
);
    logic [LO_W-1:0] lo_q [NCH];
    logic [HI_W-1:0] hi_q [NCH];

    // One register pair per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[g] <= '0;
                hi_q[g] <= '0;
            end else if (we && wr_ch == CH_W'(g)) begin
                lo_q[g] <= wr_lo;
                hi_q[g] <= wr_hi;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_ch == CH_W'(i)) begin
                rd_lo = lo_q[i];
                rd_hi = hi_q[i];
            end
        end
    end

    // R4: a write to a valid channel lands in that channel's registers
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(wr_ch) < NCH) |=>
            (lo_q[$past(wr_ch)] == $past(wr_lo) && hi_q[$past(wr_ch)] == $past(wr_hi)));

endmodule

// File: rtl/sar_adc_ctrl.sv
// Successive-approximation conversion controller, top level.
// Ties together the prescaler, start logic, search engine and result
// bank, and holds the channel sequencer that picks the next channel for
// each mode. Assumes: configuration inputs change only while idle, and
// chan_sel stays below NCH.
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int NCH         = 10,
    parameter int NMAIN       = 8,
    parameter int RES_W       = 10,
    parameter int LO_W        = 8,
    parameter int CH_W        = 4,
    parameter int CNT_W       = 6,
    parameter int T8_NOSH     = 49,
    parameter int T10_NOSH    = 59,
    parameter int T8_SH       = 28,
    parameter int T10_SH      = 33,
    parameter int SETTLE_NOSH = 5,
    parameter int SETTLE_SH   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel,
    input  logic             res10,
    input  logic             sh_en,
    input  logic [2:0]       mode,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             ext_mode,
    input  logic             ext_trig_n,
    input  logic             vref_en,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             sample_hold,
    output logic [CH_W-1:0]  chan_o,
    output logic             busy,
    output logic             start_flag,
    output logic             done,
    output logic [CH_W-1:0]  done_chan,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [LO_W-1:0]  rd_lo,
    output logic [RES_W-LO_W-1:0] rd_hi
);
    localparam int HI_W   = RES_W - LO_W;
    localparam int STEP_W = $clog2(2 * NMAIN);

    seq_mode_e         md;
    logic              tick, launch, abort, fin, eng_start;
    logic              cont, auto_clr, wrap;
    logic [RES_W-1:0]  fin_code;
    logic [STEP_W-1:0] step_q, last_step, nstep;
    logic [CH_W-1:0]   cur_ch_q, done_ch_q;
    logic              done_q;
    logic [LO_W-1:0]   wr_lo;
    logic [HI_W-1:0]   wr_hi;

    assign md = seq_mode_e'(mode);

    // Channel visited at a given step of the selected mode.
    function automatic logic [CH_W-1:0] chan_of(input logic [STEP_W-1:0] s,
                                                input seq_mode_e m,
                                                input logic [CH_W-1:0] pri);
        case (m)
            M_SWEEP, M_RSWEEP0: chan_of = CH_W'(s);
            M_RSWEEP1:          chan_of = s[0] ? CH_W'(s >> 1) : pri;
            default:            chan_of = pri;
        endcase
    endfunction

    // Sequence decode: last step, whether to continue, when to self-clear.
    always_comb begin
        case (md)
            M_SWEEP, M_RSWEEP0: last_step = STEP_W'(NMAIN - 1);
            M_RSWEEP1:          last_step = STEP_W'(2 * NMAIN - 1);
            default:            last_step = '0;
        endcase
        wrap  = (step_q == last_step);
        nstep = wrap ? '0 : step_q + STEP_W'(1);
        case (md)
            M_REPEAT, M_RSWEEP0, M_RSWEEP1: cont = start_flag;
            M_SWEEP:                        cont = !wrap;
            default:                        cont = 1'b0;
        endcase
        auto_clr  = fin && ((md == M_SWEEP) ? wrap : !(md == M_REPEAT || md == M_RSWEEP0 || md == M_RSWEEP1));
        eng_start = launch || (fin && cont && !abort);
    end

    // Step and channel registers: a launch restarts the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            cur_ch_q <= '0;
        end else if (launch) begin
            step_q   <= '0;
            cur_ch_q <= chan_of('0, md, chan_sel);
        end else if (fin && cont && !abort) begin
            step_q   <= nstep;
            cur_ch_q <= chan_of(nstep, md, chan_sel);
        end
    end

    // Result packing for the low-byte / high-bits layout.
    always_comb begin
        if (res10) begin
            wr_lo = fin_code[LO_W-1:0];
            wr_hi = fin_code[RES_W-1:LO_W];
        end else begin
            wr_lo = fin_code[RES_W-1 -: LO_W];
            wr_hi = '0;
        end
    end

    // Done pulse and its channel, registered with the result write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            done_ch_q <= '0;
        end else begin
            done_q    <= fin;
            if (fin) done_ch_q <= cur_ch_q;
        end
    end

    assign done      = done_q;
    assign done_chan = done_ch_q;
    assign chan_o    = cur_ch_q;

    sar_adc_prescaler #(.DIV_W(2)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (eng_start),
        .sel  (clk_sel),
        .tick (tick)
    );

    sar_adc_trigger u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_set  (start_set),
        .sw_clr  (start_clr),
        .auto_clr(auto_clr),
        .ext_mode(ext_mode),
        .ext_n   (ext_trig_n),
        .vref_en (vref_en),
        .flag    (start_flag),
        .launch  (launch),
        .abort   (abort)
    );

    sar_adc_engine #(
        .RES_W(RES_W), .LO_W(LO_W), .CNT_W(CNT_W),
        .T8_NOSH(T8_NOSH), .T10_NOSH(T10_NOSH), .T8_SH(T8_SH), .T10_SH(T10_SH),
        .SETTLE_NOSH(SETTLE_NOSH), .SETTLE_SH(SETTLE_SH)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (eng_start),
        .stop    (abort),
        .res10   (res10),
        .sh_en   (sh_en),
        .cmp_in  (cmp_in),
        .dac_code(dac_code),
        .sampling(sample_hold),
        .busy    (busy),
        .fin     (fin),
        .fin_code(fin_code)
    );

    sar_adc_result_bank #(.NCH(NCH), .LO_W(LO_W), .HI_W(HI_W), .CH_W(CH_W)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (fin),
        .wr_ch(cur_ch_q),
        .wr_lo(wr_lo),
        .wr_hi(wr_hi),
        .rd_ch(rd_chan),
        .rd_lo(rd_lo),
        .rd_hi(rd_hi)
    );

    // R9: a one-shot completion leaves the flag cleared
    a_r9_oneshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && md == M_ONESHOT && !launch) |=> !start_flag);

    // R14: done never lasts two cycles
    a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: a single sweep steps to the next higher channel
    a_r11_sweep_order: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && md == M_SWEEP && !wrap && !abort && !launch) |=> (chan_o == $past(chan_o) + CH_W'(1)));

    // R10: a software clear stops the run on the next cycle
    a_r10_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);

endmodule

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic       res10 = 1'b1, sh_en = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [3:0] chan_sel = 4'd0;
    logic       ext_mode = 1'b0, ext_trig_n = 1'b1, vref_en = 1'b1;
    logic       start_set = 1'b0, start_clr = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       sample_hold, busy, start_flag, done;
    logic [3:0] chan_o, done_chan, rd_chan = 4'd0;
    logic [7:0] rd_lo;
    logic [1:0] rd_hi;

    logic [9:0] vin [10];
    int n_chk = 0, n_bad = 0, cyc_total = 0;

    always #4 clk = ~clk;

    // Analog front-end model: comparator reports input >= DAC code.
    always_comb cmp_in = (chan_o < 4'd10) ? (vin[chan_o] >= dac_code) : 1'b0;

    sar_adc_ctrl u_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .res10(res10), .sh_en(sh_en),
        .mode(mode), .chan_sel(chan_sel), .ext_mode(ext_mode), .ext_trig_n(ext_trig_n),
        .vref_en(vref_en), .start_set(start_set), .start_clr(start_clr), .cmp_in(cmp_in),
        .dac_code(dac_code), .sample_hold(sample_hold), .chan_o(chan_o), .busy(busy),
        .start_flag(start_flag), .done(done), .done_chan(done_chan), .rd_chan(rd_chan),
        .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000) begin
            n_bad++;
            $display("FAIL watchdog: act=%0d expected below=150000", cyc_total);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int ticks(input logic r10, input logic sh);
        if (sh) return r10 ? 33 : 28;
        return r10 ? 59 : 49;
    endfunction

    function automatic int divof(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    // Count rising edges from the current negedge until done is seen.
    task automatic measure(output int cyc);
        cyc = -1;
        for (int k = 1; k <= 2000; k++) begin
            @(posedge clk);
            @(negedge clk);
            start_set = 1'b0;
            if (done) begin
                cyc = k;
                return;
            end
        end
    endtask

    task automatic sw_go();
        @(negedge clk);
        start_set = 1'b1;
    endtask

    task automatic sw_stop();
        @(negedge clk);
        start_clr = 1'b1;
        @(negedge clk);
        start_clr = 1'b0;
    endtask

    // Expected read-port values for a level at a resolution.
    task automatic check_read(input logic [9:0] v, input logic r10, input string req);
        int elo, ehi;
        elo = r10 ? int'(v[7:0]) : int'(v[9:2]);
        ehi = r10 ? int'(v[9:8]) : 0;
        check(int'(rd_lo) == elo, req, int'(rd_lo), elo);
        check(int'(rd_hi) == ehi, req, int'(rd_hi), ehi);
    endtask

    initial begin
        int c, idx, ch, exp_c, got;
        bit seen;
        for (int i = 0; i < 10; i++) vin[i] = 10'(i * 100 + 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R4, R14)
        check(!busy && !done && !start_flag, "R14 reset idle", int'(busy), 0);
        check(dac_code == 10'd0, "R3 reset dac", int'(dac_code), 0);
        for (int i = 0; i < 10; i++) begin
            rd_chan = 4'(i);
            #1;
            check(rd_lo == 8'd0 && rd_hi == 2'd0, "R4 reset result", int'(rd_lo), 0);
        end

        // Timing and layout over every divide, resolution and sample/hold (R1 R2 R3 R4 R5 R9 R14)
        idx = 0;
        for (int s = 0; s < 3; s++) begin
            for (int r = 0; r < 2; r++) begin
                for (int h = 0; h < 2; h++) begin
                    ch = idx % 10;
                    vin[ch] = 10'((idx * 173 + 41) % 1024);
                    clk_sel = 2'(s); res10 = r[0]; sh_en = h[0];
                    mode = 3'd0; chan_sel = 4'(ch); rd_chan = 4'(ch);
                    sw_go();
                    measure(c);
                    exp_c = divof(2'(s)) * ticks(r[0], h[0]) + 1;
                    check(c == exp_c, "R1 R2 R5 conversion length", c, exp_c);
                    check(int'(done_chan) == ch, "R14 done channel", int'(done_chan), ch);
                    check_read(vin[ch], r[0], "R3 R4 R14 result at done");
                    check(!start_flag && !busy, "R9 one-shot ends", int'(start_flag), 0);
                    @(negedge clk);
                    check(!done, "R14 done one cycle", int'(done), 0);
                    idx++;
                end
            end
        end

        // Result value sweep at both resolutions (R3 R4)
        clk_sel = 2'd0; sh_en = 1'b1; chan_sel = 4'd3; rd_chan = 4'd3;
        for (int r = 0; r < 2; r++) begin
            res10 = r[0];
            for (int k = 0; k < 34; k++) begin
                vin[3] = (k == 33) ? 10'd1023 : 10'((k * 31) % 1024);
                sw_go();
                measure(c);
                check_read(vin[3], r[0], "R3 R4 value sweep");
            end
        end

        // Reference disconnected: start ignored (R6)
        vref_en = 1'b0; res10 = 1'b1;
        sw_go();
        seen = 1'b0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            start_set = 1'b0;
            if (busy || done || start_flag) seen = 1'b1;
        end
        check(!seen, "R6 start ignored without reference", int'(seen), 0);
        vref_en = 1'b1;

        // External trigger start (R7)
        ext_mode = 1'b1; clk_sel = 2'd1; res10 = 1'b1; sh_en = 1'b0; chan_sel = 4'd8; rd_chan = 4'd8;
        vin[8] = 10'd777;
        sw_go();
        seen = 1'b0;
        for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            start_set = 1'b0;
            if (busy || done) seen = 1'b1;
        end
        check(!seen, "R7 flag alone does not start", int'(seen), 0);
        check(start_flag, "R7 flag armed", int'(start_flag), 1);
        ext_trig_n = 1'b0;
        measure(c);
        exp_c = 2 * 59 + 3;
        check(c == exp_c, "R7 external start latency", c, exp_c);
        check_read(10'd777, 1'b1, "R7 external result");

        // Retrigger during a conversion (R8)
        ext_trig_n = 1'b1;
        vin[8] = 10'd300;
        sw_go();
        repeat (4) @(negedge clk);
        start_set = 1'b0;
        ext_trig_n = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k == 30) ext_trig_n = 1'b1;
            if (done) seen = 1'b1;
        end
        check(!seen, "R8 no done before retrigger", int'(seen), 0);
        check(busy, "R8 still converting", int'(busy), 1);
        ext_trig_n = 1'b0;
        measure(c);
        check(c == exp_c, "R8 restart full length", c, exp_c);
        check_read(10'd300, 1'b1, "R8 restart result");
        ext_mode = 1'b0; ext_trig_n = 1'b1;

        // Repeat mode and software stop (R10)
        clk_sel = 2'd0; res10 = 1'b0; sh_en = 1'b1; mode = 3'd1; chan_sel = 4'd5; rd_chan = 4'd5;
        vin[5] = 10'd600;
        sw_go();
        for (int i = 0; i < 3; i++) begin
            measure(c);
            exp_c = (i == 0) ? 29 : 28;
            check(c == exp_c, "R10 repeat spacing", c, exp_c);
            check(done_chan == 4'd5 && start_flag, "R10 repeat channel", int'(done_chan), 5);
        end
        check_read(10'd600, 1'b0, "R10 repeat result");
        sw_stop();
        check(!busy && !start_flag, "R10 stopped", int'(busy), 0);
        seen = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (done || busy) seen = 1'b1;
        end
        check(!seen, "R10 no activity after stop", int'(seen), 0);

        // Single sweep (R11)
        res10 = 1'b1; mode = 3'd2;
        for (int i = 0; i < 10; i++) vin[i] = 10'(1000 - i * 90);
        sw_go();
        for (int i = 0; i < 8; i++) begin
            rd_chan = 4'(i);
            measure(c);
            exp_c = (i == 0) ? 34 : 33;
            check(c == exp_c, "R11 sweep spacing", c, exp_c);
            check(int'(done_chan) == i, "R11 sweep order", int'(done_chan), i);
            check_read(vin[i], 1'b1, "R11 sweep result");
        end
        check(!start_flag && !busy, "R11 sweep self-clears", int'(start_flag), 0);

        // Repeat sweep 0 (R12)
        mode = 3'd3;
        sw_go();
        for (int i = 0; i < 10; i++) begin
            measure(got);
            exp_c = i % 8;
            check(got > 0 && int'(done_chan) == exp_c, "R12 wrap order", int'(done_chan), exp_c);
        end
        sw_stop();

        // Repeat sweep 1 with priority channel (R13)
        mode = 3'd4; chan_sel = 4'd9;
        sw_go();
        for (int i = 0; i < 18; i++) begin
            measure(got);
            exp_c = (i % 2 == 0) ? 9 : ((i >> 1) % 8);
            check(got > 0 && int'(done_chan) == exp_c, "R13 interleave order", int'(done_chan), exp_c);
        end
        sw_stop();
        check(!busy, "R13 stopped", int'(busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule